// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

One timer channel built around a 16-bit down counter that advances on a count-tick pulse. Software gives it a start value, an operating mode and a number format (plain binary or four packed decimal digits) through a load strobe. From then on the channel decrements on each tick that the gate allows. It drives one active-high output whose waveform depends on the mode: a terminal-count flag, a periodic one-tick low pulse, or a square wave.

The count-tick input is a single-cycle enable that is synchronous to the system clock. It stands in for an external count clock that has already been edge-detected. A capture port freezes a copy of the live count, so software can read a consistent value while counting carries on underneath.

Top module: `tmr_channel`

## Requirements
- R1: After reset `out_o` is 0 and `cnt_o` reads 0.
- R2: A `load_i` pulse captures `count_i`, `mode_i` and `bcd_i`, and the loaded value shows on `cnt_o` one cycle later. A tick in the same cycle as a load is discarded.
- R3: With `bcd_i`=0 the count falls by one per enabled tick, and 16'h0000 wraps to 16'hFFFF.
- R4: With `bcd_i`=1 each nibble is a decimal digit. A digit at 0 becomes 9 and borrows from the next digit up, so 16'h0100 goes to 16'h0099 and 16'h0000 goes to 16'h9999.
- R5: A loaded value of 0 acts as the largest count. In one-shot mode the output rises after 65536 ticks in binary and after 10000 ticks in decimal.
- R6: `mode_i` values with bit 1 clear (0, 1, 4, 5) select one-shot mode. `out_o` is 0 after the load and rises on the tick that takes the count from 1 to 0. It then stays high while the count keeps wrapping, until the next load.
- R7: In one-shot mode, ticks that arrive while `gate_i` is 0 leave the count unchanged.
- R8: `mode_i` 2 or 6 selects rate mode for counts N>=2. `out_o` is high after the load and is low only while the count equals 1. The tick after that reloads N and drives the output high again, giving a period of N ticks.
- R9: `mode_i` 3 or 7 selects square mode for counts N>=2. `out_o` is high for ceil(N/2) ticks and low for floor(N/2) ticks, with automatic reload every N ticks, in both number formats.
- R10: In rate and square modes, `gate_i`=0 forces `out_o` high in the same cycle and stops counting. Raising the gate again restores the previous output level and the held count.
- R11: `cnt_o` follows the live count until `cap_i` freezes it. While it is frozen, further `cap_i` pulses have no effect. A `rd_i` pulse releases it so it shows the live count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count pulse, one cycle wide |
| gate_i | input | 1 | Count enable and output control, active high |
| load_i | input | 1 | Load strobe for count, mode and format |
| count_i | input | 16 | Initial count |
| mode_i | input | 3 | Operating mode |
| bcd_i | input | 1 | 1 selects decimal digits, 0 selects binary |
| cap_i | input | 1 | Freeze the current count on `cnt_o` |
| rd_i | input | 1 | Release a frozen count |
| cnt_o | output | 16 | Live count, or the frozen copy |
| out_o | output | 1 | Timer output |

## Verification
The bench uses the default WIDTH of 16, which gives four decimal digits. At this width both largest-count cases (65536 binary ticks and 10000 decimal ticks) fit inside the run when the tick input is held high for whole runs of cycles. The same width lets a borrow ripple across every digit from 16'h0000. Square mode is driven with an odd binary count and an even decimal count, so both the uneven and the even split of a period are seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {MODE_ONESHOT, MODE_RATE, MODE_SQUARE} tmr_mode_e;

  function automatic tmr_mode_e decode_mode(input logic [2:0] m);
    if (!m[1]) return MODE_ONESHOT;
    return m[0] ? MODE_SQUARE : MODE_RATE;
  endfunction

  function automatic logic digits_ok(input logic [63:0] v, input int nd);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < nd; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             bcd_i,
  output logic [WIDTH-1:0] val_o
);
  localparam int NDIG = WIDTH / 4;

  logic [NDIG-1:0]  brw;
  logic [WIDTH-1:0] dec_bcd;

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] d;
    assign d = val_i[4*i +: 4];
    assign dec_bcd[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (i < NDIG - 1) begin : g_brw
      assign brw[i+1] = brw[i] & (d == 4'd0);
    end
  end

  assign val_o = bcd_i ? dec_bcd : val_i - {{(WIDTH-1){1'b0}}, 1'b1};
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             bcd_i,
  output logic [WIDTH-1:0] half_o
);
  localparam int NDIG = WIDTH / 4;

  logic [WIDTH-1:0] half_bcd;
  logic             is_zero;

  assign is_zero = (val_i == '0);

  // halving packed decimal: each digit halves and takes 5 from an odd neighbour above
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] d;
    assign d = val_i[4*i +: 4];
    if (i < NDIG - 1) begin : g_mid
      assign half_bcd[4*i +: 4] = {1'b0, d[3:1]} + (val_i[4*(i+1)] ? 4'd5 : 4'd0);
    end else begin : g_top
      assign half_bcd[4*i +: 4] = {1'b0, d[3:1]};
    end
  end

  always_comb begin
    if (is_zero) half_o = bcd_i ? {4'h5, {(WIDTH-4){1'b0}}} : {1'b1, {(WIDTH-1){1'b0}}};
    else         half_o = bcd_i ? half_bcd : {1'b0, val_i[WIDTH-1:1]};
  end
endmodule

// File: rtl/tmr_latch.sv
module tmr_latch #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] live_i,
  output logic [WIDTH-1:0] val_o
);
  logic             held_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (rd_i) begin
      held_q <= 1'b0;
    end else if (cap_i && !held_q) begin
      held_q <= 1'b1;
      hold_q <= live_i;
    end
  end

  assign val_o = held_q ? hold_q : live_i;

  a_r11_frozen_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !rd_i) |=> $stable(val_o));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] count_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  input  logic             cap_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             out_o
);
  localparam int NDIG = WIDTH / 4;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] TWO = {{(WIDTH-2){1'b0}}, 2'b10};

  tmr_mode_e        mode_q, mode_in;
  logic [WIDTH-1:0] cnt_q, rld_q, half_q, half_in, dec_v;
  logic             bcd_q, out_q, step;

  assign mode_in = decode_mode(mode_i);
  assign step    = tick_i && gate_i;

  tmr_dec #(.WIDTH(WIDTH)) u_dec (
    .val_i(cnt_q), .bcd_i(bcd_q), .val_o(dec_v)
  );

  tmr_half #(.WIDTH(WIDTH)) u_half (
    .val_i(count_i), .bcd_i(bcd_i), .half_o(half_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      half_q <= '0;
      mode_q <= MODE_ONESHOT;
      bcd_q  <= 1'b0;
      out_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= count_i;
      rld_q  <= count_i;
      half_q <= half_in;
      mode_q <= mode_in;
      bcd_q  <= bcd_i;
      out_q  <= (mode_in != MODE_ONESHOT);
    end else if (step) begin
      unique case (mode_q)
        MODE_ONESHOT: begin
          cnt_q <= dec_v;
          if (cnt_q == ONE) out_q <= 1'b1;
        end
        MODE_RATE: begin
          if (cnt_q == ONE) begin
            cnt_q <= rld_q;
            out_q <= 1'b1;
          end else begin
            cnt_q <= dec_v;
            if (cnt_q == TWO) out_q <= 1'b0;
          end
        end
        default: begin
          if (cnt_q == ONE) begin
            cnt_q <= rld_q;
            out_q <= 1'b1;
          end else begin
            cnt_q <= dec_v;
            if (dec_v == half_q) out_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // periodic modes: low gate forces the output high at once
  assign out_o = out_q | ((mode_q != MODE_ONESHOT) && !gate_i);

  tmr_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_i), .rd_i(rd_i),
    .live_i(cnt_q), .val_o(cnt_o)
  );

  a_r6_load_drops_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !mode_i[1]) |=> !out_o);

  a_r7_gate_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ONESHOT && !gate_i && !load_i) |=> $stable(cnt_q));

  a_r8_rate_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RATE && step && !load_i && cnt_q == ONE) |=> (cnt_q == rld_q && out_o));

  a_r4_digits_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && bcd_q && mode_q == MODE_ONESHOT
     && digits_ok({{(64-WIDTH){1'b0}}, cnt_q}, NDIG)) |=> digits_ok({{(64-WIDTH){1'b0}}, cnt_q}, NDIG));

  a_r10_gate_forces_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_ONESHOT && !gate_i) |-> out_o);
endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, gate = 1'b1, load = 1'b0, bcd = 1'b0, cap = 1'b0, rd = 1'b0;
  logic [15:0] count = '0;
  logic [2:0]  mode = '0;
  logic [15:0] cnt;
  logic        out;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate_i(gate), .load_i(load),
    .count_i(count), .mode_i(mode), .bcd_i(bcd), .cap_i(cap), .rd_i(rd),
    .cnt_o(cnt), .out_o(out)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] c, input logic [2:0] m, input logic b);
    @(negedge clk); load = 1'b1; count = c; mode = m; bcd = b;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_cap;
    @(negedge clk); cap = 1'b1; @(negedge clk); cap = 1'b0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out", {15'd0, out}, 16'd0);
    check("R1 cnt", cnt, 16'd0);
  endtask

  task automatic t_oneshot_bin;
    do_load(16'd5, 3'd0, 1'b0);
    check("R2 loaded", cnt, 16'd5);
    check("R6 low after load", {15'd0, out}, 16'd0);
    ticks(4);
    check("R3 count", cnt, 16'd1);
    check("R6 low before zero", {15'd0, out}, 16'd0);
    ticks(1);
    check("R6 high at zero", {15'd0, out}, 16'd1);
    ticks(1);
    check("R3 wrap", cnt, 16'hFFFF);
    check("R6 stays high", {15'd0, out}, 16'd1);
  endtask

  task automatic t_gate_oneshot;
    do_load(16'd3, 3'd1, 1'b0);
    gate = 1'b0;
    ticks(2);
    check("R7 gated", cnt, 16'd3);
    gate = 1'b1;
    ticks(1);
    check("R7 resumes", cnt, 16'd2);
  endtask

  task automatic t_load_wins;
    do_load(16'd9, 3'd0, 1'b0);
    @(negedge clk); load = 1'b1; count = 16'd7; tick = 1'b1;
    @(negedge clk); load = 1'b0; tick = 1'b0;
    check("R2 load over tick", cnt, 16'd7);
  endtask

  task automatic t_bcd;
    do_load(16'h0100, 3'd0, 1'b1);
    ticks(1);
    check("R4 borrow", cnt, 16'h0099);
    do_load(16'h0000, 3'd0, 1'b1);
    ticks(1);
    check("R4 wrap", cnt, 16'h9999);
  endtask

  task automatic t_max_count;
    do_load(16'h0000, 3'd0, 1'b1);
    ticks(9999);
    check("R5 bcd before max", {15'd0, out}, 16'd0);
    check("R5 bcd count", cnt, 16'h0001);
    ticks(1);
    check("R5 bcd at max", {15'd0, out}, 16'd1);
    do_load(16'h0000, 3'd4, 1'b0);
    ticks(65535);
    check("R5 bin before max", {15'd0, out}, 16'd0);
    ticks(1);
    check("R5 bin at max", {15'd0, out}, 16'd1);
  endtask

  task automatic t_rate;
    logic [15:0] exp_c;
    do_load(16'd4, 3'd2, 1'b0);
    check("R8 high after load", {15'd0, out}, 16'd1);
    for (int k = 1; k <= 8; k++) begin
      ticks(1);
      exp_c = (k % 4 == 0) ? 16'd4 : 16'(4 - (k % 4));
      check("R8 count", cnt, exp_c);
      check("R8 out", {15'd0, out}, (exp_c == 16'd1) ? 16'd0 : 16'd1);
    end
  endtask

  task automatic t_square(input logic [15:0] ld, input int n, input logic [2:0] m, input logic b);
    int p, hi;
    hi = (n + 1) / 2;
    do_load(ld, m, b);
    check("R9 high after load", {15'd0, out}, 16'd1);
    for (int k = 1; k <= 2 * n; k++) begin
      ticks(1);
      p = k % n;
      check("R9 out", {15'd0, out}, (p == 0 || p < hi) ? 16'd1 : 16'd0);
    end
  endtask

  task automatic t_gate_periodic;
    do_load(16'd5, 3'd3, 1'b0);
    ticks(3);
    check("R10 low phase", {15'd0, out}, 16'd0);
    @(negedge clk); gate = 1'b0;
    #1;
    check("R10 forced high", {15'd0, out}, 16'd1);
    ticks(2);
    check("R10 halted", cnt, 16'd2);
    @(negedge clk); gate = 1'b1;
    #1;
    check("R10 released", {15'd0, out}, 16'd0);
    ticks(1);
    check("R10 resumes", cnt, 16'd1);
  endtask

  task automatic t_capture;
    do_load(16'd100, 3'd0, 1'b0);
    ticks(10);
    check("R11 live", cnt, 16'd90);
    pulse_cap();
    ticks(5);
    check("R11 frozen", cnt, 16'd90);
    pulse_cap();
    check("R11 second cap ignored", cnt, 16'd90);
    pulse_rd();
    check("R11 released", cnt, 16'd85);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_oneshot_bin();
    t_gate_oneshot();
    t_load_wins();
    t_bcd();
    t_rate();
    t_square(16'd5, 5, 3'd3, 1'b0);
    t_square(16'h0010, 10, 3'd7, 1'b1);
    t_gate_periodic();
    t_capture();
    t_max_count();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule